// File: doc/BRIEF.md
# Chained Masked Address Watchpoint Pair

The block watches the address bus with two comparators, unit 0 and unit 1. Each unit holds a compare value, a don't-care mask, an enable bit, a range-care bit and a range-match value. A unit matches when every address bit that its mask leaves as "care" equals the stored value. A mask bit set to 1 turns that address bit into a don't-care, so each match window covers a power-of-two-sized, aligned block of addresses.

Unit 1's raw match, taken before its enable bit, is brought out as the range signal and also feeds unit 0's range input. Unit 0 can then require that range signal to hold a chosen level. This lets the pair express windows with holes: with unit 1 covering 0x00 to 0x1F and unit 0 covering 0x00 to 0xFF while requiring range = 0, only addresses 0x20 to 0xFF raise a breakpoint.

A debug-enable input gates the outgoing debug signals. Two external condition inputs are captured on the falling clock edge. Registers are written through a small select/data/strobe port. Writes are accepted only while the core is halted.

Top module: `wpt_pair`

## Requirements
- R1: After reset, both units are disabled, both masks are all ones, both values and control fields are zero, `bkpt` is low, and `range1` is high.
- R2: A unit's address match is true when `((bus_addr ^ value) & ~mask) == 0`. A mask bit of 1 makes the matching address bit don't-care.
- R3: A unit with its enable bit (control bit 0) clear never causes `bkpt`. Unit 1 still drives `range1` from its address match regardless of its enable bit.
- R4: When unit 0's range-care bit (control bit 1) is set, unit 0 qualifies only if `range1` equals its range-match value (control bit 2). For example, with unit 1 at value 0 and mask 0x1F, and unit 0 at value 0 and mask 0xFF with range-match 0, addresses 0x20 to 0xFF break and 0x00 to 0x1F do not.
- R5: When a unit's range-care bit is clear, its range input has no effect on its match. Unit 1's range input is tied low.
- R6: `bkpt` is the OR of both units' enabled, qualified matches. It is registered on the rising clock edge, so it follows the address by one cycle.
- R7: While `dbg_en` is low, `bkpt`, `dbg_rq` and `dbg_ack` are low and `ifen` is high. While `dbg_en` is high, `dbg_rq` follows `dbg_rq_in`, `dbg_ack` follows `dbg_ack_in`, and `ifen` is the inverse of `dbg_ack_in`.
- R8: `ext_q` takes the value of `ext_in` at each falling clock edge and resets to 0.
- R9: A register write made while `run` is high is discarded.
- R10: Write select: `wr_sel[2]` picks the unit. `wr_sel[1:0]` picks the field: 0 is the value, 1 is the mask, 2 is the control field (data bits [2:0]). Field code 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Debug enable; low forces the debug outputs to idle |
| run | input | 1 | Core running; writes are blocked while high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Unit and field select |
| wr_data | input | AW | Write data |
| bus_addr | input | AW | Address being watched |
| ext_in | input | 2 | External condition inputs |
| dbg_rq_in | input | 1 | Debug request from the host side |
| dbg_ack_in | input | 1 | Debug acknowledge from the core |
| bkpt | output | 1 | Registered breakpoint |
| dbg_rq | output | 1 | Gated debug request |
| dbg_ack | output | 1 | Gated debug acknowledge |
| ifen | output | 1 | Interrupt enable to the core |
| range1 | output | 1 | Unit 1 raw address match |
| ext_q | output | 2 | Falling-edge samples of `ext_in` |

## Verification
The bench builds the block with a 16-bit address (AW = 16). At that width the all-ones reset mask, a compare on the top address bit, and the full 0x20 to 0xFF hole-window example all fit in short literal vectors. The width is still wide enough that an address just past the 256-byte window, or one with only bit 15 set, exercises the unmasked upper bits.

// File: rtl/wpt_pair.sv
module wpt_pair #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_en,
  input  logic          run,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    ext_in,
  input  logic          dbg_rq_in,
  input  logic          dbg_ack_in,
  output logic          bkpt,
  output logic          dbg_rq,
  output logic          dbg_ack,
  output logic          ifen,
  output logic          range1,
  output logic [1:0]    ext_q
);

  logic [AW-1:0] val0, val1, msk0, msk1;
  logic [2:0]    ctl0, ctl1;
  logic          hit0, hit1, qual0, qual1, bkpt_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val0 <= '0;
      val1 <= '0;
      msk0 <= '1;
      msk1 <= '1;
      ctl0 <= '0;
      ctl1 <= '0;
    end else if (wr_en && !run) begin
      case (wr_sel)
        3'b000:  val0 <= wr_data;
        3'b001:  msk0 <= wr_data;
        3'b010:  ctl0 <= wr_data[2:0];
        3'b100:  val1 <= wr_data;
        3'b101:  msk1 <= wr_data;
        3'b110:  ctl1 <= wr_data[2:0];
        default: ;
      endcase
    end
  end

  assign hit0   = ((bus_addr ^ val0) & ~msk0) == '0;
  assign hit1   = ((bus_addr ^ val1) & ~msk1) == '0;
  assign range1 = hit1;

  assign qual0 = hit0 && (!ctl0[1] || (range1 == ctl0[2]));
  assign qual1 = hit1 && (!ctl1[1] || !ctl1[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bkpt_r <= 1'b0;
    else        bkpt_r <= dbg_en && ((ctl0[0] && qual0) || (ctl1[0] && qual1));
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 2'b00;
    else        ext_q <= ext_in;
  end

  assign bkpt    = dbg_en && bkpt_r;
  assign dbg_rq  = dbg_en && dbg_rq_in;
  assign dbg_ack = dbg_en && dbg_ack_in;
  assign ifen    = !dbg_en || !dbg_ack_in;

endmodule

module wpt_pair_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dbg_en,
  input logic          run,
  input logic          wr_en,
  input logic          bkpt,
  input logic          dbg_rq,
  input logic          dbg_ack,
  input logic          ifen,
  input logic [1:0]    ext_in,
  input logic [1:0]    ext_q,
  input logic [AW-1:0] val0,
  input logic [AW-1:0] val1,
  input logic [AW-1:0] msk0,
  input logic [AW-1:0] msk1,
  input logic [2:0]    ctl0,
  input logic [2:0]    ctl1
);

  logic seen_fall;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) seen_fall <= 1'b0;
    else        seen_fall <= 1'b1;
  end

  assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_en |-> (!bkpt && !dbg_rq && !dbg_ack && ifen));

  assert_bkpt_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt |-> $past(dbg_en));

  assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl0[0] && !ctl1[0]) |=> !bkpt);

  assert_run_locks_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en) |=> ($stable(val0) && $stable(val1) && $stable(msk0) &&
                        $stable(msk1) && $stable(ctl0) && $stable(ctl1)));

  assert_ext_fall_sample_R8: assert property (@(negedge clk) disable iff (!rst_n)
    seen_fall |-> (ext_q == $past(ext_in)));

endmodule

bind wpt_pair wpt_pair_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .run(run), .wr_en(wr_en),
  .bkpt(bkpt), .dbg_rq(dbg_rq), .dbg_ack(dbg_ack), .ifen(ifen),
  .ext_in(ext_in), .ext_q(ext_q), .val0(val0), .val1(val1),
  .msk0(msk0), .msk1(msk1), .ctl0(ctl0), .ctl1(ctl1)
);

// File: tb/wpt_pair_tb.sv
module wpt_pair_tb;
  localparam int AW = 16;
  localparam int NV = 9;
  // {address, expected bkpt, expected range1} for the hole-window setup (R4)
  localparam logic [AW+1:0] VEC [NV] = '{
    {16'h0000, 1'b0, 1'b1}, {16'h001F, 1'b0, 1'b1}, {16'h0010, 1'b0, 1'b1},
    {16'h0020, 1'b1, 1'b0}, {16'h0080, 1'b1, 1'b0}, {16'h00FF, 1'b1, 1'b0},
    {16'h0100, 1'b0, 1'b0}, {16'h8020, 1'b0, 1'b0}, {16'h0040, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, dbg_en = 1'b1, run = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [AW-1:0] wr_data = '0, bus_addr = '0;
  logic [1:0] ext_in = '0;
  logic dbg_rq_in = 1'b0, dbg_ack_in = 1'b0;
  logic bkpt, dbg_rq, dbg_ack, ifen, range1;
  logic [1:0] ext_q;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wpt_pair #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .run(run), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .bus_addr(bus_addr), .ext_in(ext_in),
    .dbg_rq_in(dbg_rq_in), .dbg_ack_in(dbg_ack_in), .bkpt(bkpt),
    .dbg_rq(dbg_rq), .dbg_ack(dbg_ack), .ifen(ifen), .range1(range1), .ext_q(ext_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // drive an address, then sample one rising edge later (R6 latency)
  task automatic probe(input logic [AW-1:0] a, input logic eb, input logic er, input string req);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #1;
    chk(bkpt == eb, req, bkpt, eb);
    chk(range1 == er, req, range1, er);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(bkpt == 1'b0, "R1 bkpt", bkpt, 0);
    chk(range1 == 1'b1, "R1 range1", range1, 1);
    chk(ext_q == 2'b00, "R1 ext_q", ext_q, 0);
    rst_n = 1'b1;
    probe(16'h1234, 1'b0, 1'b1, "R1 reset disabled");

    // unit1: value 0, mask 0x1F, disabled; unit0: value 0, mask 0xFF, enable+care, match 0
    wr(3'b100, 16'h0000);
    wr(3'b101, 16'h001F);
    wr(3'b110, 16'h0000);
    wr(3'b000, 16'h0000);
    wr(3'b001, 16'h00FF);
    wr(3'b010, 16'h0003);
    for (int i = 0; i < NV; i++)
      probe(VEC[i][AW+1:2], VEC[i][1], VEC[i][0], "R2 R3 R4 vector");

    // R6: output lags by one edge
    probe(16'h0000, 1'b0, 1'b1, "R6 setup");
    @(negedge clk); bus_addr = 16'h0030; #1;
    chk(bkpt == 1'b0, "R6 before edge", bkpt, 0);
    @(posedge clk); #1;
    chk(bkpt == 1'b1, "R6 after edge", bkpt, 1);

    // R4: range-match value 1 inverts the hole
    wr(3'b010, 16'h0007);
    probe(16'h0010, 1'b1, 1'b1, "R4 inside inner");
    probe(16'h0020, 1'b0, 1'b0, "R4 outside inner");

    // R5: care cleared, range ignored
    wr(3'b010, 16'h0005);
    probe(16'h0005, 1'b1, 1'b1, "R5 care clear");
    probe(16'h0200, 1'b0, 1'b0, "R5 miss");

    // R6: OR of units, unit1 enabled alone triggers
    wr(3'b010, 16'h0003);
    wr(3'b110, 16'h0001);
    probe(16'h0003, 1'b1, 1'b1, "R6 unit1 alone");
    probe(16'h0050, 1'b1, 1'b0, "R6 unit0 alone");
    wr(3'b110, 16'h0000);

    // R10: field code 3 writes nothing
    wr(3'b011, 16'hFFFF);
    wr(3'b111, 16'hFFFF);
    probe(16'h0020, 1'b1, 1'b0, "R10 code3");
    probe(16'h0008, 1'b0, 1'b1, "R10 code3 hole");

    // R9: writes while running are dropped
    run = 1'b1;
    wr(3'b000, 16'h0F00);
    wr(3'b010, 16'h0000);
    run = 1'b0;
    probe(16'h0020, 1'b1, 1'b0, "R9 run lock");

    // R7: gating
    dbg_rq_in = 1'b1; dbg_ack_in = 1'b1;
    probe(16'h0020, 1'b1, 1'b0, "R7 enabled");
    chk(dbg_rq == 1'b1, "R7 rq pass", dbg_rq, 1);
    chk(dbg_ack == 1'b1, "R7 ack pass", dbg_ack, 1);
    chk(ifen == 1'b0, "R7 ifen ack", ifen, 0);
    @(negedge clk); dbg_en = 1'b0; #1;
    chk(bkpt == 1'b0, "R7 bkpt gated", bkpt, 0);
    chk(dbg_rq == 1'b0, "R7 rq gated", dbg_rq, 0);
    chk(dbg_ack == 1'b0, "R7 ack gated", dbg_ack, 0);
    chk(ifen == 1'b1, "R7 ifen forced", ifen, 1);
    @(posedge clk); #1;
    chk(bkpt == 1'b0, "R7 bkpt gated reg", bkpt, 0);
    @(negedge clk); dbg_en = 1'b1; dbg_ack_in = 1'b0; dbg_rq_in = 1'b0;
    @(posedge clk); #1;
    chk(bkpt == 1'b1, "R7 re-enabled", bkpt, 1);
    chk(ifen == 1'b1, "R7 ifen no ack", ifen, 1);

    // R8: falling-edge capture
    ext_in = 2'b10; #1;
    chk(ext_q == 2'b00, "R8 before fall", ext_q, 0);
    @(negedge clk); #1;
    chk(ext_q == 2'b10, "R8 at fall", ext_q, 2);
    ext_in = 2'b01;
    @(posedge clk); #1;
    chk(ext_q == 2'b10, "R8 rise no capture", ext_q, 2);
    @(negedge clk); #1;
    chk(ext_q == 2'b01, "R8 next fall", ext_q, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule